// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh duty of an asynchronous DRAM. After reset it holds the memory bus quiet for a programmable power-up pause. It then runs a burst of initialization refresh cycles and raises a done flag. From that point on it schedules one refresh every programmable interval. The default interval is 3900 clocks of 4 ns, which spreads 2048 row refreshes evenly over 32 ms.

The controller shares the RAS, CAS, WE and address pins with an access sequencer. It asks for them with a request line and starts a cycle only once the grant is high. It owns the pins from that edge until the end of the cycle's precharge. A select input picks the refresh style for each cycle:
- **CAS-before-RAS**: CAS leads RAS and is held low through the whole RAS pulse.
- **RAS-only**: CAS stays high and the controller presents its own row counter on the address bus.

If the grant comes late, missed refresh slots are queued up to a fixed limit. Each completed refresh cycle retires one queued slot.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: For PAUSE_CYC clocks after reset, ref_req, ref_own and init_done are 0, ras_n and cas_n are 1, and addr is 0.
- R2: When the pause ends, ref_req rises and INIT_CYC refresh cycles are run. init_done rises on the edge that ends the last of them, and it stays 1 until reset.
- R3: Beginning INTERVAL_CYC clocks after init_done rises, one refresh slot is added every INTERVAL_CYC clocks. The queue saturates at PEND_MAX slots. Each completed cycle removes one slot. ref_req is 1 while slots are queued or a cycle is running.
- R4: A cycle starts only on an edge where the controller is idle, ref_req is 1 and ref_gnt is 1. ref_own is 1 from that edge until the edge that ends precharge. While ref_own is 0, ras_n and cas_n are 1 and addr is 0.
- R5: In a CAS-before-RAS cycle (ras_only_sel=0 at the start edge), the phases run in this order:
  - cas_n is 0 for LEAD_CYC clocks with ras_n at 1;
  - both are 0 for RAS_CYC clocks;
  - both are 1 for PRE_CYC clocks.
  addr is 0 throughout the cycle.
- R6: In a RAS-only cycle (ras_only_sel=1 at the start edge), cas_n stays 1 for the whole cycle. addr carries the row count during the LEAD_CYC lead clocks and the RAS_CYC clocks of ras_n=0. ras_n is then 1 and addr is 0 for PRE_CYC clocks.
- R7: The row count starts at 0 after reset and advances by one at the end of each RAS-only cycle. It wraps from 2^ROW_W-1 to 0. CAS-before-RAS cycles leave it unchanged.
- R8: we_n is 1 at all times.
- R9: ras_only_sel is sampled only at the start edge. Changing it during a cycle has no effect on that cycle's ras_n, cas_n and addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_only_sel | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| ref_gnt | input | 1 | Grant of the DRAM pins from the arbiter |
| ref_req | output | 1 | Request for the DRAM pins |
| ref_own | output | 1 | Controller is driving the DRAM pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| addr | output | ROW_W | Row address for RAS-only refresh |
| init_done | output | 1 | Power-up sequence complete |

## Verification
The assertions check these properties on every cycle:
- a pin takeover is always preceded by grant and request;
- CAS never changes on the edge where RAS falls, and never rises while both strobes are low;
- the row count only ever steps by one;
- the queue never exceeds its limit once initialization is over;
- init_done rises only as a cycle closes.

The bench's scenarios are needed for the rest:
- the exact phase lengths and the pause length;
- the count of initialization cycles and the spacing of periodic slots;
- saturation after a long grant stall;
- the row wrap;
- immunity to a mode change in the middle of a cycle.

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int PAUSE_CYC    = 50000,
  parameter int INIT_CYC     = 8,
  parameter int INTERVAL_CYC = 3900,
  parameter int LEAD_CYC     = 2,
  parameter int RAS_CYC      = 13,
  parameter int PRE_CYC      = 8,
  parameter int PEND_MAX     = 8,
  parameter int ROW_W        = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_sel,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic             init_done
);
  localparam int QMAX  = (INIT_CYC > PEND_MAX) ? INIT_CYC : PEND_MAX;
  localparam int CNT_W = $clog2(QMAX + 1);
  localparam int T1    = (PAUSE_CYC > RAS_CYC) ? PAUSE_CYC : RAS_CYC;
  localparam int T2    = (LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC;
  localparam int TMR_W = $clog2(((T1 > T2) ? T1 : T2) + 1);
  localparam int ITV_W = $clog2(INTERVAL_CYC + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_LEAD, S_RAS, S_PRE} st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [ITV_W-1:0] itmr;
  logic [CNT_W-1:0] pending;
  logic [ROW_W-1:0] row;
  logic             cyc_ro;
  logic             done, tick, start, inc;

  assign start = (st == S_IDLE) && (pending != '0) && ref_gnt;
  assign done  = (st == S_PRE) && (tmr == '0);
  assign tick  = init_done && (itmr == '0);
  assign inc   = tick && ((pending < CNT_W'(PEND_MAX)) || done);

  assign ref_own = (st == S_LEAD) || (st == S_RAS) || (st == S_PRE);
  assign ref_req = (st != S_PAUSE) && ((pending != '0) || ref_own);
  assign ras_n   = (st != S_RAS);
  assign cas_n   = !(!cyc_ro && ((st == S_LEAD) || (st == S_RAS)));
  assign we_n    = 1'b1;
  assign addr    = (cyc_ro && ((st == S_LEAD) || (st == S_RAS))) ? row : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PAUSE;
      tmr    <= TMR_W'(PAUSE_CYC - 1);
      cyc_ro <= 1'b0;
    end else begin
      case (st)
        S_PAUSE: if (tmr == '0) st <= S_IDLE; else tmr <= tmr - 1'b1;
        S_IDLE: if (start) begin
          st     <= S_LEAD;
          tmr    <= TMR_W'(LEAD_CYC - 1);
          cyc_ro <= ras_only_sel;
        end
        S_LEAD: if (tmr == '0) begin
          st  <= S_RAS;
          tmr <= TMR_W'(RAS_CYC - 1);
        end else tmr <= tmr - 1'b1;
        S_RAS: if (tmr == '0) begin
          st  <= S_PRE;
          tmr <= TMR_W'(PRE_CYC - 1);
        end else tmr <= tmr - 1'b1;
        S_PRE: if (tmr == '0) st <= S_IDLE; else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= '0;
      init_done <= 1'b0;
      row       <= '0;
    end else begin
      if (st == S_PAUSE && tmr == '0)
        pending <= CNT_W'(INIT_CYC);
      else
        pending <= pending + CNT_W'(inc) - CNT_W'(done);
      if (done && !init_done && pending == CNT_W'(1))
        init_done <= 1'b1;
      if (done && cyc_ro)
        row <= row + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        itmr <= ITV_W'(INTERVAL_CYC - 1);
    else if (!init_done || itmr == '0) itmr <= ITV_W'(INTERVAL_CYC - 1);
    else                               itmr <= itmr - 1'b1;
  end

  p_quiet_before_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !ref_req) |-> (ras_n && cas_n && addr == '0));
  p_init_at_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> ($past(ref_own) && !ref_own));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (pending <= CNT_W'(PEND_MAX)));
  p_own_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_own) |-> ($past(ref_gnt) && $past(ref_req)));
  p_cas_steady_at_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($stable(cas_n) && $past(ref_own)));
  p_cas_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !cas_n) |=> (ras_n || !cas_n));
  p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |-> (row == $past(row) + 1'b1));
endmodule

// File: tb/dram_refresh_ctrl_tb_top.sv
module dram_refresh_ctrl_tb_top;
  localparam int PAUSE = 20, INIT = 8, ITV = 40, LEAD = 1, RASC = 3, PRE = 2;
  localparam int PMAX = 3, RW = 5, ROWS = 32, CYC = LEAD + RASC + PRE;

  logic clk = 0, rst_n = 0, sel = 0, gnt = 0;
  logic ref_req, ref_own, ras_n, cas_n, we_n, init_done;
  logic [RW-1:0] addr;

  always #2 clk = ~clk;

  dram_refresh_ctrl #(.PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .INTERVAL_CYC(ITV),
    .LEAD_CYC(LEAD), .RAS_CYC(RASC), .PRE_CYC(PRE), .PEND_MAX(PMAX), .ROW_W(RW))
  dut_i (.clk(clk), .rst_n(rst_n), .ras_only_sel(sel), .ref_gnt(gnt),
    .ref_req(ref_req), .ref_own(ref_own), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .init_done(init_done));

  int n_chk = 0, n_bad = 0;
  int m_pause, m_pend, m_since, m_pos, m_row;
  bit m_init, m_ro;
  bit finished = 0;

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pause = PAUSE; m_pend = 0; m_since = 0; m_pos = -1; m_row = 0;
      m_init = 0; m_ro = 0;
    end else begin
      bit was_init;
      was_init = m_init;
      if (m_pause > 0) begin
        m_pause--;
        if (m_pause == 0) m_pend = INIT;
      end else if (m_pos < 0) begin
        if (m_pend > 0 && gnt) begin m_pos = 0; m_ro = sel; end
      end else begin
        m_pos++;
        if (m_pos == CYC) begin
          m_pos = -1;
          m_pend--;
          if (m_ro) m_row = (m_row + 1) % ROWS;
          if (!m_init && m_pend == 0) m_init = 1;
        end
      end
      if (was_init) begin
        m_since++;
        if (m_since == ITV) begin
          m_since = 0;
          if (m_pend < PMAX) m_pend++;
        end
      end
    end
  end

  int last_ro = -1;
  bit wrap_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string t_str;
      int e_ras, e_cas, e_addr;
      bit in_lead, in_ras;
      in_lead = (m_pos >= 0 && m_pos < LEAD);
      in_ras  = (m_pos >= LEAD && m_pos < LEAD + RASC);
      e_ras  = in_ras ? 0 : 1;
      e_cas  = (!m_ro && (in_lead || in_ras)) ? 0 : 1;
      e_addr = (m_ro && (in_lead || in_ras)) ? m_row : 0;
      t_str  = (m_pause > 0) ? "R1" : (m_ro ? "R6" : "R5");
      cmp({t_str, " ras_n"}, ras_n, e_ras);
      cmp({t_str, " cas_n"}, cas_n, e_cas);
      cmp({(m_pause > 0) ? "R1" : "R7", " addr"}, addr, e_addr);
      cmp({(m_pause > 0) ? "R1" : "R3", " ref_req"}, ref_req,
          (m_pause == 0 && (m_pend > 0 || m_pos >= 0)) ? 1 : 0);
      cmp("R4 ref_own", ref_own, (m_pos >= 0) ? 1 : 0);
      cmp("R2 init_done", init_done, m_init);
      cmp("R8 we_n", we_n, 1);
      if (!ras_n && cas_n) begin
        if (last_ro == ROWS - 1 && addr == 0) wrap_seen = 1;
        last_ro = addr;
      end
    end
  end

  logic [7:0] lfsr = 8'h5a;

  initial begin
    int falls;
    logic prev_ras;
    repeat (3) @(negedge clk);
    cmp("R1 reset init_done", init_done, 0);
    cmp("R1 reset ref_req", ref_req, 0);
    gnt = 1;
    rst_n = 1;
    repeat (PAUSE - 2) @(negedge clk);
    cmp("R1 pause ref_req", ref_req, 0);
    repeat (2) @(negedge clk);
    cmp("R2 req after pause", ref_req, 1);
    repeat (INIT * (CYC + 1) + 4) @(negedge clk);
    cmp("R2 init_done after init burst", init_done, 1);
    repeat (200) @(negedge clk);
    gnt = 0;                                   // R3 stall the grant
    repeat (300) @(negedge clk);
    cmp("R3 req during stall", ref_req, 1);
    gnt = 1;
    falls = 0;
    prev_ras = ras_n;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (prev_ras && !ras_n) falls++;
      prev_ras = ras_n;
    end
    cmp("R3 saturated burst size ok", (falls >= PMAX && falls <= PMAX + 1) ? 1 : 0, 1);
    sel = 1;
    repeat ((ROWS + 4) * ITV) @(negedge clk);
    cmp("R7 row wrap observed", wrap_seen, 1);
    for (int i = 0; i < 800; i++) begin        // R9 toggle mode and grant freely
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sel = lfsr[0];
      gnt = lfsr[1] | lfsr[2];
      @(negedge clk);
    end
    rst_n = 0;
    @(negedge clk);
    cmp("R1 reset again ras_n", ras_n, 1);
    cmp("R1 reset again init_done", init_done, 0);
    rst_n = 1;
    sel = 0;
    gnt = 1;
    repeat (PAUSE + INIT * (CYC + 1) + 200) @(negedge clk);
    cmp("R2 init_done second run", init_done, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule